// File: doc/BRIEF.md
# PHY Register Handshake Master

This block gives a controller indirect access to the 16-bit internal registers of a PHY. The PHY offers no memory-mapped window into those registers. Instead it exposes a narrow control word and a status word. The control word carries a shared data/address field and four strobes: capture-address, capture-data, write and read. The status word returns an acknowledge bit and a 16-bit read-data field.

Each access is split into phases. Every phase is a complete four-phase exchange: the strobe is raised, acknowledge is awaited high, the strobe is dropped, and acknowledge is awaited low. Each wait is bounded by a poll budget, so a silent or stuck PHY ends the access with an error instead of a hang.

On the command side, a request is offered with `cmd_valid` and taken when `cmd_ready` is high. The rules are:
- `cmd_ready` is high only while the block is idle.
- A request offered while busy is not taken and has no effect. The requester keeps it, or drops it, at its own choice.
- The response has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_err` and `rsp_rdata` in that cycle.

Top module: `phy_hs_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `phy_ctl` is zero, `busy` is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: `phy_ctl` places the data/address field at bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. At most one of bits 19:16 is ever high. `phy_stat` bit 16 is acknowledge and bits 15:0 are read data.
- R3: Every access starts with the address phase. The sequence of distinct `phy_ctl` words is: the address alone, then the address with capture-address (after which acknowledge is awaited high), then the address alone again (after which acknowledge is awaited low). The address is unchanged when capture-address rises.
- R4: A write (`cmd_write`=1) continues with these words: the data alone, the data with capture-data, the data alone, the write strobe alone with a zero field, the data alone, and finally all zeros. After each strobe word acknowledge is awaited high; after each following word it is awaited low.
- R5: A read (`cmd_write`=0) continues after the address phase with the read strobe alone. When acknowledge is seen high, it latches `phy_stat[15:0]`, drives all zeros, and waits for acknowledge low. `rsp_rdata` then carries the latched value and changes at no other time.
- R6: Within one wait, acknowledge is checked first on the cycle the wait begins and then every `DELAY_CYCLES` cycles, for at most `MAX_POLLS` checks. An acknowledge that arrives within that budget lets the access finish without error.
- R7: If the expected acknowledge level is not seen by the last check, the access aborts: `phy_ctl` goes to zero, and `rsp_valid` and `rsp_err` are high together for one cycle. With acknowledge stuck low, this happens `9*DELAY_CYCLES+2` cycles after acceptance (default `MAX_POLLS`=10). With acknowledge stuck high, it happens one cycle later.
- R8: A request is accepted only when `cmd_ready` is high. `busy` rises in the cycle after acceptance and stays high up to and including the `rsp_valid` cycle. A `cmd_valid` seen while busy is ignored and causes no bus activity.
- R9: Every access ends with exactly one single-cycle `rsp_valid` pulse. `rsp_err` is low in that cycle on success, and `cmd_ready` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Block idle and able to take a request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access aborted on acknowledge timeout |
| rsp_rdata | output | 16 | Data from the latest successful read |
| phy_ctl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
Writes and reads use a PHY model whose acknowledge follows the strobes after a chosen delay. Zero and short delays show that the word sequence and field positions come out right regardless of acknowledge speed. A long delay that still fits in the poll budget tells correct polling apart from a premature timeout. Acknowledge stuck low and acknowledge stuck high give different abort times, which shows whether the expected level is compared in the right phase. Writing to and reading back from two different addresses tells whether the address and data fields are latched and routed correctly. A request offered while busy has to leave the bus sequence and the response count unchanged.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SET,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_SET,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL,
    ST_DONE,
    ST_FAIL
  } hs_state_e;

  // strobe offsets above the data field
  localparam int STB_CAP_ADDR = 0;
  localparam int STB_CAP_DATA = 1;
  localparam int STB_WRITE    = 2;
  localparam int STB_READ     = 3;
  localparam int STB_COUNT    = 4;

  function automatic logic waits_for_ack(hs_state_e s);
    case (s)
      ST_ADDR_CAP, ST_ADDR_REL, ST_DATA_CAP, ST_DATA_REL,
      ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic wants_ack_high(hs_state_e s);
    case (s)
      ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hs_ack_poller.sv
module hs_ack_poller #(
  parameter int DELAY_CYCLES = 250,
  parameter int MAX_POLLS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic expect_lvl,
  input  logic ack,
  output logic hit,
  output logic tmo
);
  localparam int DLY_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam int PC_W  = $clog2(MAX_POLLS + 1);
  localparam logic [DLY_W-1:0] DLY_RELOAD = DLY_W'(DELAY_CYCLES - 1);
  localparam logic [PC_W-1:0]  LAST_POLL  = PC_W'(MAX_POLLS - 1);

  logic [DLY_W-1:0] dly_q;
  logic [PC_W-1:0]  polls_q;
  logic             check_now;
  logic             level_ok;

  assign check_now = go && (dly_q == '0);
  assign level_ok  = (ack == expect_lvl);
  assign hit       = check_now && level_ok;
  assign tmo       = check_now && !level_ok && (polls_q == LAST_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q   <= '0;
      polls_q <= '0;
    end else if (!go || hit || tmo) begin
      dly_q   <= '0;
      polls_q <= '0;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else begin
      dly_q   <= DLY_RELOAD;
      polls_q <= polls_q + 1'b1;
    end
  end

  // R6
  poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (polls_q <= LAST_POLL));

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
  import phy_hs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CTL_W = DATA_W + STB_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              hit,
  input  logic              tmo,
  input  logic [DATA_W-1:0] rd_field,
  output logic              poll_go,
  output logic              poll_expect,
  output logic [CTL_W-1:0]  ctl_word,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  hs_state_e         st_q, st_d;
  logic              is_wr_q;
  logic [DATA_W-1:0] addr_q, data_q, addr_n, data_n;
  logic [DATA_W-1:0] rdata_q;
  logic [CTL_W-1:0]  ctl_q, ctl_d;

  assign addr_n = cmd_fire ? cmd_addr  : addr_q;
  assign data_n = cmd_fire ? cmd_wdata : data_q;

  always_comb begin
    st_d = st_q;
    if (waits_for_ack(st_q) && tmo) begin
      st_d = ST_FAIL;
    end else begin
      case (st_q)
        ST_IDLE:     if (cmd_fire) st_d = ST_ADDR_SET;
        ST_ADDR_SET: st_d = ST_ADDR_CAP;
        ST_ADDR_CAP: if (hit) st_d = ST_ADDR_REL;
        ST_ADDR_REL: if (hit) st_d = is_wr_q ? ST_DATA_SET : ST_RD_STB;
        ST_DATA_SET: st_d = ST_DATA_CAP;
        ST_DATA_CAP: if (hit) st_d = ST_DATA_REL;
        ST_DATA_REL: if (hit) st_d = ST_WR_STB;
        ST_WR_STB:   if (hit) st_d = ST_WR_REL;
        ST_WR_REL:   if (hit) st_d = ST_DONE;
        ST_RD_STB:   if (hit) st_d = ST_RD_REL;
        ST_RD_REL:   if (hit) st_d = ST_DONE;
        ST_DONE:     st_d = ST_IDLE;
        ST_FAIL:     st_d = ST_IDLE;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  // word driven while in the next state
  always_comb begin
    ctl_d = '0;
    case (st_d)
      ST_ADDR_SET, ST_ADDR_REL: ctl_d[DATA_W-1:0] = addr_n;
      ST_ADDR_CAP: begin
        ctl_d[DATA_W-1:0]             = addr_n;
        ctl_d[DATA_W + STB_CAP_ADDR]  = 1'b1;
      end
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL: ctl_d[DATA_W-1:0] = data_n;
      ST_DATA_CAP: begin
        ctl_d[DATA_W-1:0]             = data_n;
        ctl_d[DATA_W + STB_CAP_DATA]  = 1'b1;
      end
      ST_WR_STB: ctl_d[DATA_W + STB_WRITE] = 1'b1;
      ST_RD_STB: ctl_d[DATA_W + STB_READ]  = 1'b1;
      default:   ctl_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ctl_q   <= '0;
    end else begin
      st_q  <= st_d;
      ctl_q <= ctl_d;
      if (cmd_fire) begin
        is_wr_q <= cmd_write;
        addr_q  <= cmd_addr;
        data_q  <= cmd_wdata;
      end
      if (st_q == ST_RD_STB && hit) rdata_q <= rd_field;
    end
  end

  assign poll_go     = waits_for_ack(st_q);
  assign poll_expect = wants_ack_high(st_q);
  assign ctl_word    = ctl_q;
  assign busy        = (st_q != ST_IDLE);
  assign rsp_valid   = (st_q == ST_DONE) || (st_q == ST_FAIL);
  assign rsp_err     = (st_q == ST_FAIL);
  assign rsp_rdata   = rdata_q;

  // R5
  rdata_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(st_q) == ST_RD_STB);

  // R9
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DELAY_CYCLES = 250,
  parameter int MAX_POLLS    = 10,
  localparam int CTL_W  = DATA_W + STB_COUNT,
  localparam int STAT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CTL_W-1:0]  phy_ctl,
  input  logic [STAT_W-1:0] phy_stat
);
  logic poll_go, poll_expect, hit, tmo, cmd_fire;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;

  hs_ack_poller #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) poll_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (poll_go),
    .expect_lvl(poll_expect),
    .ack       (phy_stat[DATA_W]),
    .hit       (hit),
    .tmo       (tmo)
  );

  hs_sequencer #(.DATA_W(DATA_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_fire   (cmd_fire),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .hit        (hit),
    .tmo        (tmo),
    .rd_field   (phy_stat[DATA_W-1:0]),
    .poll_go    (poll_go),
    .poll_expect(poll_expect),
    .ctl_word   (phy_ctl),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctl[CTL_W-1:DATA_W]));

  // R3
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctl[DATA_W + STB_CAP_ADDR]) |-> $stable(phy_ctl[DATA_W-1:0]));

  // R4
  wr_field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctl[DATA_W + STB_WRITE] |-> (phy_ctl[DATA_W-1:0] == '0));

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (phy_ctl == '0));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy && !cmd_ready);

  // R8
  busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

endmodule

// File: tb/phy_hs_master_tb_top.sv
`timescale 1ns/1ps
module phy_hs_master_tb_top;
  localparam int D  = 4;
  localparam int MP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready, busy, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [19:0] phy_ctl;
  logic [16:0] phy_stat;

  phy_hs_master #(.DELAY_CYCLES(D), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .phy_ctl(phy_ctl), .phy_stat(phy_stat));

  // PHY model
  int          ack_lat = 1;
  int          ack_mode = 0;   // 0 follow, 1 stuck low, 2 stuck high
  int          lag = 0;
  logic        ack = 1'b0;
  logic [19:0] prev_ctl = '0;
  logic [15:0] cap_a = '0, cap_d = '0;
  logic [15:0] mem [8];
  wire         tgt = |phy_ctl[19:16];
  assign phy_stat = {ack, mem[cap_a[2:0]]};

  initial for (int i = 0; i < 8; i++) mem[i] = 16'h1100 + 16'(i);

  always @(posedge clk) begin
    prev_ctl <= phy_ctl;
    if (phy_ctl[16] && !prev_ctl[16]) cap_a <= phy_ctl[15:0];
    if (phy_ctl[17] && !prev_ctl[17]) cap_d <= phy_ctl[15:0];
    if (phy_ctl[18] && !prev_ctl[18]) mem[cap_a[2:0]] <= cap_d;
    if (ack_mode == 1) ack <= 1'b0;
    else if (ack_mode == 2) ack <= 1'b1;
    else if (ack != tgt) begin
      if (lag >= ack_lat) begin ack <= tgt; lag <= 0; end
      else lag <= lag + 1;
    end else lag <= 0;
  end

  // control word log
  logic [19:0] log_a [32];
  int          log_n = 0;
  logic [19:0] last_seen = '0;
  int          rsp_cnt = 0;
  always @(negedge clk) begin
    if (phy_ctl != last_seen) begin
      if (log_n < 32) log_a[log_n] = phy_ctl;
      log_n++;
      last_seen = phy_ctl;
    end
    if (rsp_valid) rsp_cnt++;
  end

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_n = 0;
    last_seen = phy_ctl;
    rsp_cnt = 0;
  endtask

  // returns cycles counted in negedges after acceptance
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        output int n, output bit err, output logic [15:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 3000) begin @(negedge clk); n++; end
    err = rsp_err;
    rd  = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R9", "pulse width", 32'(rsp_valid), 0);
    chk(cmd_ready, "R9", "ready after done", 32'(cmd_ready), 1);
  endtask

  task automatic t_reset();
    chk(phy_ctl == 0, "R1", "ctl in reset", 32'(phy_ctl), 0);
    chk(!busy && cmd_ready && !rsp_valid, "R1", "idle flags",
        {busy, cmd_ready, rsp_valid}, 32'b010);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d, input int lat);
    int n; bit err; logic [15:0] rd;
    logic [19:0] exp [9];
    ack_lat = lat;
    clear_log();
    access(1'b1, a, d, n, err, rd);
    exp = '{{4'h0, a}, {4'h1, a}, {4'h0, a}, {4'h0, d}, {4'h2, d}, {4'h0, d},
            20'h40000, {4'h0, d}, 20'h0};
    chk(!err, "R9", "write err", 32'(err), 0);
    chk(log_n == 9, "R4", "write word count", 32'(log_n), 9);
    for (int i = 0; i < 9; i++)
      chk(log_a[i] == exp[i], (i < 3) ? "R3" : "R4", "write word", 32'(log_a[i]), 32'(exp[i]));
  endtask

  task automatic t_read(input logic [15:0] a, input logic [15:0] expd, input int lat);
    int n; bit err; logic [15:0] rd;
    logic [19:0] exp [5];
    ack_lat = lat;
    clear_log();
    access(1'b0, a, 16'h0, n, err, rd);
    exp = '{{4'h0, a}, {4'h1, a}, {4'h0, a}, 20'h80000, 20'h0};
    chk(!err, "R9", "read err", 32'(err), 0);
    chk(rd == expd, "R5", "read data", 32'(rd), 32'(expd));
    chk(log_n == 5, "R5", "read word count", 32'(log_n), 5);
    for (int i = 0; i < 5; i++)
      chk(log_a[i] == exp[i], (i < 3) ? "R3" : "R5", "read word", 32'(log_a[i]), 32'(exp[i]));
  endtask

  task automatic t_late();
    int n; bit err; logic [15:0] rd;
    ack_lat = 30;
    access(1'b0, 16'h0203, 16'h0, n, err, rd);
    chk(!err, "R6", "late ack within budget", 32'(err), 0);
    chk(rd == 16'hc3e1, "R6", "late ack data", 32'(rd), 32'hc3e1);
    ack_lat = 1;
  endtask

  task automatic t_timeout(input int mode, input int exp_n);
    int n; bit err; logic [15:0] rd;
    ack_mode = mode;
    access(1'b1, 16'h0104, 16'h7777, n, err, rd);
    chk(err, "R7", "timeout err", 32'(err), 1);
    chk(n == exp_n, "R7", "timeout cycle", 32'(n), 32'(exp_n));
    chk(phy_ctl == 0, "R7", "ctl after abort", 32'(phy_ctl), 0);
    ack_mode = 0;
    repeat (10) @(negedge clk);
    chk(mem[4] == 16'h1104, "R7", "aborted write left reg", 32'(mem[4]), 32'h1104);
  endtask

  task automatic t_busy_ignore();
    ack_lat = 1;
    clear_log();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0106; cmd_wdata = 16'h2468;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0707;
    chk(busy && !cmd_ready, "R8", "busy while active", {busy, cmd_ready}, 32'b10);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3000 && !rsp_valid; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(rsp_cnt == 1, "R8", "responses", 32'(rsp_cnt), 1);
    chk(log_n == 9, "R8", "words with ignored req", 32'(log_n), 9);
    chk(mem[6] == 16'h2468, "R8", "write landed", 32'(mem[6]), 32'h2468);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(16'h0105, 16'h5a3c, 2);
    t_read(16'h0105, 16'h5a3c, 2);
    t_write(16'h0203, 16'hc3e1, 0);
    t_read(16'h0203, 16'hc3e1, 0);
    t_read(16'h0105, 16'h5a3c, 3);
    t_late();
    t_timeout(1, 9 * D + 3);
    t_timeout(2, 9 * D + 4);
    t_busy_ignore();
    finish_run();
  end
endmodule